// File: doc/BRIEF.md
# Byte-Spanning Bitfield Memory Accessor

This unit reads or rewrites a bit field of 1 to 32 bits in a big-endian, byte-addressed memory. A request names a base byte address, a starting bit position within that first byte, and a field width. Bit positions count from the most significant bit of the base byte, and a field may run on across several following bytes. The unit works out how many bytes the field touches. It fetches those bytes one at a time over a byte-wide request/ready port into a 64-bit working buffer, with the lowest-addressed byte in the top eight bits of that buffer.

For a read, the field is returned right-aligned and zero-extended. For a write, the unit first reads the covered bytes and replaces only the field bits in the buffer. It then writes the same bytes back in the same order, so every other bit in those bytes keeps its value. A one-cycle completion pulse marks the end of either operation. Address translation and bus faults are left to the surrounding logic.

Top module: `bitfield_mem_access`

## Requirements
- R1: A request with bit position `o` (0..7) and effective width `w` moves exactly floor((o + w + 7) / 8) bytes in each of its phases, at consecutive addresses starting at the base address. No other address is touched.
- R2: On a read, `rd_field` returns the field right-aligned and zero-extended. Its most significant valid bit is bit `7-o` of the base byte, and the following field bits continue toward lower-significance bits and then into higher addresses.
- R3: A write reads every covered byte before writing any byte. It then writes back the same count of bytes to the same addresses. Only the `w` field bits, taken from the low `w` bits of `wr_field`, change in memory.
- R4: While `busy` is high, `start` is ignored. Outside an operation `mem_req` stays low.
- R5: Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` hold their values until a cycle in which `mem_ready` is high.
- R6: `done` is high for exactly one cycle per operation. On a write, `rd_field` carries the field value as it was before the write.
- R7: A width code of 0 on `fld_width` selects a 32-bit field. Codes 1..31 select that many bits.
- R8: After reset, `mem_req`, `done`, `busy` and `rd_field` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| wr_en | input | 1 | 1 = write field, 0 = read field |
| base_addr | input | ADDR_W | Byte address of the first covered byte |
| bit_off | input | 3 | Starting bit position, 0 = MSB of base byte |
| fld_width | input | 5 | Field width, 0 encodes 32 |
| wr_field | input | 32 | New field value, right-aligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_field | output | 32 | Field read (old value on writes), right-aligned |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Byte address of the transfer |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | 8 | Read byte, valid in a cycle with `mem_req` and `mem_ready` high |

## Verification
The checker assumes two things about the memory side. `mem_rdata` is valid whenever a read is accepted, and `mem_ready` may be withheld for any number of cycles. The checker also assumes that `start` is sampled only while the unit is idle. Its byte-count bound of five depends on the bit position never exceeding 7.

The stimulus applies `start` only through a task that waits for `done`, except in one case where a second `start` is deliberately issued during a busy operation. The memory model withholds `mem_ready` in one cycle out of three, so the hold rule is exercised. Every base address is chosen so that a five-byte field stays inside the modelled memory.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SPLICE = 2'd2,
    ST_STORE = 2'd3
  } bfa_state_e;
endpackage

// File: rtl/bfa_span.sv
module bfa_span #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 32,
  parameter int OFF_W   = 3,
  parameter int WID_W   = 5,
  parameter int CNT_W   = 3
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [WID_W-1:0] wcode_i,
  output logic [WID_W:0]   eff_w_o,
  output logic [CNT_W-1:0] nbytes_o
);
  localparam int SUM_W = WID_W + 2;
  logic [SUM_W-1:0] span_sum;

  always_comb begin
    eff_w_o  = (wcode_i == '0) ? (WID_W+1)'(FIELD_W) : {1'b0, wcode_i};
    span_sum = SUM_W'(off_i) + SUM_W'(eff_w_o) + SUM_W'(BYTE_W - 1);
    nbytes_o = CNT_W'(span_sum / SUM_W'(BYTE_W));
  end
endmodule

// File: rtl/bfa_extract.sv
module bfa_extract #(
  parameter int BUF_W   = 64,
  parameter int FIELD_W = 32,
  parameter int OFF_W   = 3,
  parameter int WID_W   = 5
) (
  input  logic [BUF_W-1:0]   buf_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [WID_W:0]     eff_w_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam int SH_W = $clog2(BUF_W) + 1;
  logic [BUF_W-1:0] lifted;
  logic [BUF_W-1:0] lowered;

  always_comb begin
    lifted  = buf_i << off_i;
    lowered = lifted >> (SH_W'(BUF_W) - SH_W'(eff_w_i));
    field_o = lowered[FIELD_W-1:0];
  end
endmodule

// File: rtl/bfa_merge.sv
module bfa_merge #(
  parameter int BUF_W   = 64,
  parameter int FIELD_W = 32,
  parameter int OFF_W   = 3,
  parameter int WID_W   = 5
) (
  input  logic [BUF_W-1:0]   buf_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [WID_W:0]     eff_w_i,
  input  logic [FIELD_W-1:0] data_i,
  output logic [BUF_W-1:0]   buf_o
);
  localparam int SH_W = $clog2(BUF_W) + 1;
  logic [BUF_W-1:0] top_ones;
  logic [BUF_W-1:0] keep_mask;
  logic [BUF_W-1:0] placed;

  always_comb begin
    top_ones  = ~({BUF_W{1'b1}} >> eff_w_i);
    keep_mask = top_ones >> off_i;
    placed    = ({{(BUF_W-FIELD_W){1'b0}}, data_i} << (SH_W'(BUF_W) - SH_W'(eff_w_i))) >> off_i;
    buf_o     = (buf_i & ~keep_mask) | (placed & keep_mask);
  end
endmodule

// File: rtl/bitfield_mem_access.sv
module bitfield_mem_access #(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 32,
  parameter int BUF_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [2:0]        bit_off,
  input  logic [4:0]        fld_width,
  input  logic [31:0]       wr_field,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rd_field,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata
);
  import bfa_pkg::*;

  localparam int OFF_W  = $clog2(BYTE_W);
  localparam int WID_W  = $clog2(FIELD_W);
  localparam int NLANES = BUF_W / BYTE_W;
  localparam int CNT_W  = $clog2(NLANES);

  bfa_state_e        state_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  nbytes_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [WID_W:0]    eff_w_q;
  logic [FIELD_W-1:0] data_q;
  logic              wr_q;
  logic              done_q;
  logic [FIELD_W-1:0] rd_q;

  logic [WID_W:0]     span_w;
  logic [CNT_W-1:0]   span_n;
  logic [BUF_W-1:0]   buf_flat;
  logic [BUF_W-1:0]   buf_spliced;
  logic [FIELD_W-1:0] field_now;
  logic [BYTE_W-1:0]  lane_q [NLANES];

  logic accept, xfer, last_byte;

  assign accept    = (state_q == ST_IDLE) && start;
  assign xfer      = mem_req && mem_ready;
  assign last_byte = (idx_q == nbytes_q - CNT_W'(1));

  bfa_span #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W), .OFF_W(OFF_W), .WID_W(WID_W), .CNT_W(CNT_W)) u_span (
    .off_i(bit_off[OFF_W-1:0]), .wcode_i(fld_width[WID_W-1:0]),
    .eff_w_o(span_w), .nbytes_o(span_n)
  );

  bfa_extract #(.BUF_W(BUF_W), .FIELD_W(FIELD_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_extract (
    .buf_i(buf_flat), .off_i(off_q), .eff_w_i(eff_w_q), .field_o(field_now)
  );

  bfa_merge #(.BUF_W(BUF_W), .FIELD_W(FIELD_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_merge (
    .buf_i(buf_flat), .off_i(off_q), .eff_w_i(eff_w_q), .data_i(data_q), .buf_o(buf_spliced)
  );

  // One register per byte lane; lane 0 is the lowest address, top of buffer.
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int HI = BUF_W - 1 - g * BYTE_W;
    assign buf_flat[HI -: BYTE_W] = lane_q[g];

    always_ff @(posedge clk) begin
      if (rst || accept) begin
        lane_q[g] <= '0;
      end else if (state_q == ST_FETCH && mem_ready && idx_q == CNT_W'(g)) begin
        lane_q[g] <= mem_rdata;
      end else if (state_q == ST_SPLICE && wr_q) begin
        lane_q[g] <= buf_spliced[HI -: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      nbytes_q <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      off_q    <= '0;
      eff_w_q  <= '0;
      data_q   <= '0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q   <= base_addr;
            addr_q   <= base_addr;
            off_q    <= bit_off[OFF_W-1:0];
            eff_w_q  <= span_w;
            nbytes_q <= span_n;
            data_q   <= wr_field[FIELD_W-1:0];
            wr_q     <= wr_en;
            idx_q    <= '0;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            if (last_byte) begin
              state_q <= ST_SPLICE;
            end else begin
              idx_q  <= idx_q + CNT_W'(1);
              addr_q <= addr_q + ADDR_W'(1);
            end
          end
        end
        ST_SPLICE: begin
          rd_q <= field_now;
          if (wr_q) begin
            idx_q   <= '0;
            addr_q  <= base_q;
            state_q <= ST_STORE;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_STORE: begin
          if (mem_ready) begin
            if (last_byte) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_q + CNT_W'(1);
              addr_q <= addr_q + ADDR_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign rd_field  = rd_q;
  assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_addr  = addr_q;
  assign mem_wdata = lane_q[idx_q];

  logic unused_xfer;
  assign unused_xfer = xfer;
endmodule

// File: rtl/bfa_checker.sv
module bfa_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata
);
  logic [3:0] rd_cnt, wr_cnt;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (mem_req && mem_ready) begin
      if (mem_we) wr_cnt <= wr_cnt + 4'd1;
      else        rd_cnt <= rd_cnt + 4'd1;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_byte_count_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_cnt >= 4'd1 && rd_cnt <= 4'd5));

  p_no_read_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (wr_cnt == 4'd0));

  p_write_count_r3: assert property (@(posedge clk) disable iff (rst)
    (done && wr_cnt != 4'd0) |-> (wr_cnt == rd_cnt));
endmodule

bind bitfield_mem_access bfa_checker #(.ADDR_W(ADDR_W)) u_bfa_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_bitfield_mem_access.sv
module test_bitfield_mem_access;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 16;
  localparam int NVEC = 11;

  // {wr, addr[3:0], off[2:0], wcode[4:0], data[31:0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 4'd2, 3'd0, 5'd8,  32'h0},
    {1'b0, 4'd3, 3'd5, 5'd3,  32'h0},
    {1'b0, 4'd3, 3'd5, 5'd4,  32'h0},
    {1'b0, 4'd0, 3'd7, 5'd0,  32'h0},
    {1'b1, 4'd4, 3'd3, 5'd10, 32'h0000_02AB},
    {1'b0, 4'd4, 3'd3, 5'd10, 32'h0},
    {1'b1, 4'd6, 3'd7, 5'd0,  32'hDEAD_BEEF},
    {1'b0, 4'd6, 3'd7, 5'd0,  32'h0},
    {1'b1, 4'd1, 3'd0, 5'd1,  32'hFFFF_FFFF},
    {1'b1, 4'd9, 3'd4, 5'd17, 32'h0001_F0F0},
    {1'b0, 4'd8, 3'd1, 5'd31, 32'h0}
  };

  logic clk = 0, rst = 1;
  logic start = 0, wr_en = 0;
  logic [15:0] base_addr = '0;
  logic [2:0] bit_off = '0;
  logic [4:0] fld_width = '0;
  logic [31:0] wr_field = '0;
  logic busy, done, mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] rd_field;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [MEM_N];
  logic [7:0] ref_mem [MEM_N];
  int rd_n, wr_n, bad_addr, hold_bad, cur_base, cur_n, stall_ctr;
  logic prev_stall;
  logic [15:0] prev_addr;
  logic prev_we;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_mem_access i_bitfield_mem_access (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .base_addr(base_addr),
    .bit_off(bit_off), .fld_width(fld_width), .wr_field(wr_field),
    .busy(busy), .done(done), .rd_field(rd_field),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[3:0]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_n <= rd_n + 1;
      end
      if (int'(mem_addr) < cur_base || int'(mem_addr) >= cur_base + cur_n)
        bad_addr <= bad_addr + 1;
    end
    if (prev_stall && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
      hold_bad <= hold_bad + 1;
    prev_stall <= mem_req && !mem_ready;
    prev_addr  <= mem_addr;
    prev_we    <= mem_we;
  end

  always @(negedge clk) begin
    stall_ctr <= stall_ctr + 1;
    mem_ready <= (stall_ctr % 3) != 2;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff_width(input logic [4:0] c);
    return (c == 0) ? 32 : int'(c);
  endfunction

  function automatic logic [31:0] ref_get(input int a, input int o, input int w);
    logic [31:0] f = '0;
    for (int i = 0; i < w; i++) begin
      int p = o + i;
      f = {f[30:0], ref_mem[a + p/8][7 - p%8]};
    end
    return f;
  endfunction

  task automatic ref_put(input int a, input int o, input int w, input logic [31:0] d);
    for (int i = 0; i < w; i++) begin
      int p = o + i;
      ref_mem[a + p/8][7 - p%8] = d[w - 1 - i];
    end
  endtask

  task automatic run_op(input logic wr, input int a, input int o, input logic [4:0] wc,
                        input logic [31:0] d, output bit timed_out);
    int guard = 0;
    timed_out = 0;
    @(negedge clk);
    rd_n = 0; wr_n = 0; bad_addr = 0;
    cur_base = a; cur_n = (o + eff_width(wc) + 7) / 8;
    wr_en = wr; base_addr = 16'(a); bit_off = 3'(o); fld_width = wc; wr_field = d;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    if (!done) timed_out = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit to;
    logic [31:0] exp_f;
    int n_exp;
    rd_n = 0; wr_n = 0; bad_addr = 0; hold_bad = 0; cur_base = 0; cur_n = 0;
    stall_ctr = 0; prev_stall = 0; prev_addr = '0; prev_we = 0;
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 37) ^ 8'hA5;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R8 mem_req", 32'(mem_req), 0);
    check("R8 done", 32'(done), 0);
    check("R8 busy", 32'(busy), 0);
    check("R8 rd_field", rd_field, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic vw = VEC[v][44];
      int va = int'(VEC[v][43:40]);
      int vo = int'(VEC[v][39:37]);
      logic [4:0] vc = VEC[v][36:32];
      logic [31:0] vd = VEC[v][31:0];
      int w = eff_width(vc);
      n_exp = (vo + w + 7) / 8;
      exp_f = ref_get(va, vo, w);          // R2, R7: old field value
      if (vw) ref_put(va, vo, w, vd);
      run_op(vw, va, vo, vc, vd, to);
      if (to) begin
        fails++; tests++;
        $display("FAIL R6 no done on vector %0d", v);
        continue;
      end
      check(vw ? "R6 old field on write" : "R2 read field", rd_field, exp_f);
      check("R1 read byte count", 32'(rd_n), 32'(n_exp));
      check("R3 write byte count", 32'(wr_n), vw ? 32'(n_exp) : 0);
      check("R1 address window", 32'(bad_addr), 0);
      @(negedge clk);
      check("R6 done one cycle", 32'(done), 0);
      begin
        int diff = 0;
        for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) diff++;
        check("R3 memory image", 32'(diff), 0);
      end
    end

    // R4: second start while busy must be ignored
    n_exp = (2 + 6 + 7) / 8;
    exp_f = ref_get(5, 2, 6);
    @(negedge clk);
    rd_n = 0; wr_n = 0; bad_addr = 0; cur_base = 5; cur_n = n_exp;
    wr_en = 0; base_addr = 16'd5; bit_off = 3'd2; fld_width = 5'd6; start = 1;
    @(negedge clk);
    wr_en = 1; base_addr = 16'd0; bit_off = 3'd0; fld_width = 5'd0; wr_field = 32'h0; start = 1;
    @(negedge clk);
    start = 0;
    begin
      int guard = 0;
      while (!done && guard < 400) begin @(negedge clk); guard++; end
    end
    check("R4 field of first request", rd_field, exp_f);
    check("R4 write ignored", 32'(wr_n), 0);
    check("R4 address window", 32'(bad_addr), 0);
    repeat (4) @(negedge clk);
    check("R4 idle no request", 32'(mem_req), 0);
    check("R4 idle not busy", 32'(busy), 0);
    begin
      int diff = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) diff++;
      check("R4 memory untouched", 32'(diff), 0);
    end
    check("R5 hold under stall", 32'(hold_bad), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule